// File: doc/BRIEF.md
# Indirect 32-to-64-bit Register Bridge

This block lets a host with a 32-bit register bus reach a space of 64-bit registers through a small window. The host places the upper half of a value in one data word and the lower half in another. It then writes a command word. Bit 31 of the command word selects the direction, and its low bits give a register index. That single command write starts one atomic 64-bit access on an internal register port. For a read, the 64-bit result comes back into the two data words, where the host can fetch it. The internal address is the index plus a fixed region offset and a per-instance base, which arrives on a strap input.

The host side is a request channel and a response channel, each with valid/ready. A request completes when valid and ready are high on the same edge. Its single response appears on the next cycle. The response holds still until the host raises response ready, and no new request is taken while a response is still waiting. While an internal access is in flight, the bridge pushes back on the data and command words by holding request ready low. The status, reset and interrupt-enable words are still served during that time. A failed internal access sets a sticky error flag. Only a write to the reset word clears it. An interrupt pin reports the flag when it is enabled.

The internal port issues a request with valid/ready and holds it until it is taken. It then accepts exactly one response, which carries a data word and an error flag. There is no response-ready on the internal side: the bridge always takes a response while it waits for one.

Top module: `wide_reg_bridge`

## Requirements
- R1: After reset, no response is pending, no internal request is raised, `irq_o` is 0, and every readable window word reads 0.
- R2: The window decodes byte offsets 0x00 (upper data word, bits 63:32), 0x04 (lower data word, bits 31:0), 0x08 (command), 0x18 (reset), 0x1C (status) and 0x20 (interrupt enable). Any other offset gets a response with `h_rsp_err`=1 and rdata 0, and changes no state. The reset word reads as 0.
- R3: A request is taken when `h_req_valid` and `h_req_ready` are both high at a clock edge. Exactly one response follows in the next cycle. While `h_rsp_ready` is low, the response keeps valid, data and error unchanged, and no further request is taken.
- R4: A command write with bit 31 = 1 issues one internal write whose 64-bit data is {upper word, lower word}.
- R5: A command write with bit 31 = 0 issues one internal read. If that read succeeds, the result's bits 63:32 land in the upper data word and its bits 31:0 land in the lower data word.
- R6: The internal address is REGION_BASE (default 0x70000) + `inst_base` + command bits [IDX_W-1:0]. The internal request keeps valid, address, data and direction stable until `i_req_ready` is high.
- R7: Status bit 0 reads 1 from the accepted command write until the internal response arrives. During that time, requests to 0x00, 0x04 and 0x08 see `h_req_ready` low, while status, reset and interrupt-enable requests are still served.
- R8: An internal response with the error flag set sets status bit 31, and the bit stays set. A failed read leaves both data words unchanged.
- R9: A write of any value to the reset word clears status bit 31. If an internal error response arrives on the same edge as that write, bit 31 stays set.
- R10: Bit 0 of the interrupt-enable word is read/write. `irq_o` equals status bit 31 AND that enable bit.
- R11: Reading the command word returns the last command value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inst_base | input | IAW | Per-instance base added to every internal address |
| h_req_valid | input | 1 | Host request valid |
| h_req_ready | output | 1 | Host request ready |
| h_req_write | input | 1 | 1 = write, 0 = read |
| h_req_addr | input | HAW | Window byte offset |
| h_req_wdata | input | HDW | Host write data |
| h_rsp_valid | output | 1 | Host response valid |
| h_rsp_ready | input | 1 | Host response ready |
| h_rsp_rdata | output | HDW | Read data (0 for writes) |
| h_rsp_err | output | 1 | Unmapped window offset |
| i_req_valid | output | 1 | Internal request valid |
| i_req_ready | input | 1 | Internal request ready |
| i_req_write | output | 1 | Internal direction, 1 = write |
| i_req_addr | output | IAW | Internal register address |
| i_req_wdata | output | 2*HDW | Internal write data |
| i_rsp_valid | input | 1 | Internal response valid |
| i_rsp_rdata | input | 2*HDW | Internal read data |
| i_rsp_err | input | 1 | Internal access failed (unmapped) |
| irq_o | output | 1 | Error interrupt |

## Verification
The error flag has two writers that can act on the same edge: an internal error response sets it, and a host write to the reset word clears it. To make them meet, the bench stops answering the internal port automatically. It issues a command, then at one falling edge raises both the internal response and a reset-word host request, so both are taken at the next rising edge. When the response carries an error, status bit 31 must read back as 1. When the response is clean, a second run must read it back as 0 and must find the read result in the data words.

// File: rtl/wide_reg_bridge_pkg.sv
package wide_reg_bridge_pkg;

  localparam logic [7:0] OFF_HI     = 8'h00;
  localparam logic [7:0] OFF_LO     = 8'h04;
  localparam logic [7:0] OFF_CMD    = 8'h08;
  localparam logic [7:0] OFF_CLR    = 8'h18;
  localparam logic [7:0] OFF_STAT   = 8'h1C;
  localparam logic [7:0] OFF_IRQEN  = 8'h20;

  localparam int CMD_DIR_BIT  = 31;
  localparam int STAT_ERR_BIT = 31;
  localparam int STAT_BSY_BIT = 0;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_HI,
    SEL_LO,
    SEL_CMD,
    SEL_CLR,
    SEL_STAT,
    SEL_IRQEN
  } win_sel_e;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_ISSUE,
    ENG_WAIT
  } eng_state_e;

endpackage

// File: rtl/wide_reg_bridge_decode.sv
module wide_reg_bridge_decode
  import wide_reg_bridge_pkg::*;
#(
  parameter int HAW = 8
) (
  input  logic [HAW-1:0] addr,
  output win_sel_e       sel,
  output logic           gated
);

  localparam int HI_W = (HAW > 8) ? HAW - 8 : 1;

  logic upper_zero;

  generate
    if (HAW > 8) begin : g_wide
      assign upper_zero = (addr[HAW-1:8] == '0);
    end else begin : g_narrow
      assign upper_zero = 1'b1;
    end
  endgenerate

  always_comb begin
    sel = SEL_NONE;
    if (upper_zero) begin
      case (addr[7:0])
        OFF_HI:    sel = SEL_HI;
        OFF_LO:    sel = SEL_LO;
        OFF_CMD:   sel = SEL_CMD;
        OFF_CLR:   sel = SEL_CLR;
        OFF_STAT:  sel = SEL_STAT;
        OFF_IRQEN: sel = SEL_IRQEN;
        default:   sel = SEL_NONE;
      endcase
    end
  end

  // words that must wait while an internal access is in flight
  assign gated = (sel == SEL_HI) || (sel == SEL_LO) || (sel == SEL_CMD);

  logic [HI_W-1:0] unused_w;
  assign unused_w = '0;

endmodule

// File: rtl/wide_reg_bridge_host.sv
module wide_reg_bridge_host #(
  parameter int HDW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic           stall,
  input  logic [HDW-1:0] rd_data,
  input  logic           rd_err,
  output logic           accept,
  output logic           rsp_valid,
  input  logic           rsp_ready,
  output logic [HDW-1:0] rsp_rdata,
  output logic           rsp_err
);

  logic           pend_q;
  logic [HDW-1:0] data_q;
  logic           err_q;

  assign req_ready = !pend_q && !stall;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      data_q <= '0;
      err_q  <= 1'b0;
    end else if (accept) begin
      pend_q <= 1'b1;
      data_q <= (req_write || rd_err) ? '0 : rd_data;
      err_q  <= rd_err;
    end else if (pend_q && rsp_ready) begin
      pend_q <= 1'b0;
    end
  end

  assign rsp_valid = pend_q;
  assign rsp_rdata = data_q;
  assign rsp_err   = err_q;

endmodule

// File: rtl/wide_reg_bridge_regs.sv
module wide_reg_bridge_regs
  import wide_reg_bridge_pkg::*;
#(
  parameter int HDW = 32,
  localparam int IDW = 2 * HDW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           accept,
  input  logic           req_write,
  input  win_sel_e       sel,
  input  logic [HDW-1:0] wdata,
  input  logic           busy,
  input  logic           done,
  input  logic           done_rd,
  input  logic           done_err,
  input  logic [IDW-1:0] done_rdata,
  output logic [HDW-1:0] rd_data,
  output logic           rd_err,
  output logic           start,
  output logic [HDW-1:0] cmd_word,
  output logic [IDW-1:0] wide_wdata,
  output logic           err_flag,
  output logic           irq
);

  logic [HDW-1:0] hi_q, lo_q, cmd_q;
  logic           err_q, irqen_q;
  logic           wr_acc, err_set, err_clr;

  assign wr_acc  = accept && req_write;
  assign start   = wr_acc && (sel == SEL_CMD);
  assign err_set = done && done_err;
  assign err_clr = wr_acc && (sel == SEL_CLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      lo_q    <= '0;
      cmd_q   <= '0;
      err_q   <= 1'b0;
      irqen_q <= 1'b0;
    end else begin
      if (done && done_rd && !done_err) begin
        hi_q <= done_rdata[IDW-1:HDW];
        lo_q <= done_rdata[HDW-1:0];
      end else begin
        if (wr_acc && sel == SEL_HI) hi_q <= wdata;
        if (wr_acc && sel == SEL_LO) lo_q <= wdata;
      end
      if (start) cmd_q <= wdata;
      if (wr_acc && sel == SEL_IRQEN) irqen_q <= wdata[0];
      // a fresh error outranks a clear in the same cycle
      if (err_set)      err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    rd_err  = 1'b0;
    case (sel)
      SEL_HI:    rd_data = hi_q;
      SEL_LO:    rd_data = lo_q;
      SEL_CMD:   rd_data = cmd_q;
      SEL_STAT: begin
        rd_data[STAT_ERR_BIT] = err_q;
        rd_data[STAT_BSY_BIT] = busy;
      end
      SEL_IRQEN: rd_data[0] = irqen_q;
      SEL_CLR:   rd_data = '0;
      default:   rd_err = 1'b1;
    endcase
  end

  assign cmd_word   = wdata;
  assign wide_wdata = {hi_q, lo_q};
  assign err_flag   = err_q;
  assign irq        = err_q && irqen_q;

endmodule

// File: rtl/wide_reg_bridge_engine.sv
module wide_reg_bridge_engine
  import wide_reg_bridge_pkg::*;
#(
  parameter int HDW = 32,
  parameter int IAW = 20,
  parameter int IDX_W = 8,
  parameter logic [IAW-1:0] REGION_BASE = 20'h70000,
  localparam int IDW = 2 * HDW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [IAW-1:0] inst_base,
  input  logic           start,
  input  logic [HDW-1:0] cmd_word,
  input  logic [IDW-1:0] wide_wdata,
  output logic           busy,
  output logic           done,
  output logic           done_rd,
  output logic           i_req_valid,
  input  logic           i_req_ready,
  output logic           i_req_write,
  output logic [IAW-1:0] i_req_addr,
  output logic [IDW-1:0] i_req_wdata,
  input  logic           i_rsp_valid
);

  eng_state_e     state_q;
  logic           wr_q;
  logic [IAW-1:0] addr_q;
  logic [IDW-1:0] wd_q;
  logic [IAW-1:0] addr_nxt;

  assign addr_nxt = REGION_BASE + inst_base +
                    {{(IAW-IDX_W){1'b0}}, cmd_word[IDX_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wd_q    <= '0;
    end else begin
      case (state_q)
        ENG_IDLE: if (start) begin
          state_q <= ENG_ISSUE;
          wr_q    <= cmd_word[CMD_DIR_BIT];
          addr_q  <= addr_nxt;
          wd_q    <= wide_wdata;
        end
        ENG_ISSUE: if (i_req_ready) state_q <= ENG_WAIT;
        ENG_WAIT:  if (i_rsp_valid) state_q <= ENG_IDLE;
        default:   state_q <= ENG_IDLE;
      endcase
    end
  end

  assign busy        = (state_q != ENG_IDLE);
  assign done        = (state_q == ENG_WAIT) && i_rsp_valid;
  assign done_rd     = !wr_q;
  assign i_req_valid = (state_q == ENG_ISSUE);
  assign i_req_write = wr_q;
  assign i_req_addr  = addr_q;
  assign i_req_wdata = wd_q;

endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge
  import wide_reg_bridge_pkg::*;
#(
  parameter int HAW = 8,
  parameter int HDW = 32,
  parameter int IAW = 20,
  parameter int IDX_W = 8,
  parameter logic [IAW-1:0] REGION_BASE = 20'h70000,
  localparam int IDW = 2 * HDW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [IAW-1:0] inst_base,
  input  logic           h_req_valid,
  output logic           h_req_ready,
  input  logic           h_req_write,
  input  logic [HAW-1:0] h_req_addr,
  input  logic [HDW-1:0] h_req_wdata,
  output logic           h_rsp_valid,
  input  logic           h_rsp_ready,
  output logic [HDW-1:0] h_rsp_rdata,
  output logic           h_rsp_err,
  output logic           i_req_valid,
  input  logic           i_req_ready,
  output logic           i_req_write,
  output logic [IAW-1:0] i_req_addr,
  output logic [IDW-1:0] i_req_wdata,
  input  logic           i_rsp_valid,
  input  logic [IDW-1:0] i_rsp_rdata,
  input  logic           i_rsp_err,
  output logic           irq_o
);

  win_sel_e       sel;
  logic           gated, stall, accept;
  logic [HDW-1:0] rd_data;
  logic           rd_err;
  logic           start;
  logic [HDW-1:0] cmd_word;
  logic [IDW-1:0] wide_wdata;
  logic           busy, eng_done, done_rd, err_flag;

  wide_reg_bridge_decode #(.HAW(HAW)) u_dec (
    .addr  (h_req_addr),
    .sel   (sel),
    .gated (gated)
  );

  assign stall = busy && gated;

  wide_reg_bridge_host #(.HDW(HDW)) u_host (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (h_req_valid),
    .req_ready (h_req_ready),
    .req_write (h_req_write),
    .stall     (stall),
    .rd_data   (rd_data),
    .rd_err    (rd_err),
    .accept    (accept),
    .rsp_valid (h_rsp_valid),
    .rsp_ready (h_rsp_ready),
    .rsp_rdata (h_rsp_rdata),
    .rsp_err   (h_rsp_err)
  );

  wide_reg_bridge_regs #(.HDW(HDW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .req_write  (h_req_write),
    .sel        (sel),
    .wdata      (h_req_wdata),
    .busy       (busy),
    .done       (eng_done),
    .done_rd    (done_rd),
    .done_err   (i_rsp_err),
    .done_rdata (i_rsp_rdata),
    .rd_data    (rd_data),
    .rd_err     (rd_err),
    .start      (start),
    .cmd_word   (cmd_word),
    .wide_wdata (wide_wdata),
    .err_flag   (err_flag),
    .irq        (irq_o)
  );

  wide_reg_bridge_engine #(
    .HDW(HDW), .IAW(IAW), .IDX_W(IDX_W), .REGION_BASE(REGION_BASE)
  ) u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .inst_base   (inst_base),
    .start       (start),
    .cmd_word    (cmd_word),
    .wide_wdata  (wide_wdata),
    .busy        (busy),
    .done        (eng_done),
    .done_rd     (done_rd),
    .i_req_valid (i_req_valid),
    .i_req_ready (i_req_ready),
    .i_req_write (i_req_write),
    .i_req_addr  (i_req_addr),
    .i_req_wdata (i_req_wdata),
    .i_rsp_valid (i_rsp_valid)
  );

endmodule

// File: rtl/wide_reg_bridge_chk.sv
module wide_reg_bridge_chk
  import wide_reg_bridge_pkg::*;
#(
  parameter int HAW = 8,
  parameter int HDW = 32,
  parameter int IAW = 20,
  localparam int IDW = 2 * HDW
) (
  input logic           clk,
  input logic           rst_n,
  input logic           h_req_valid,
  input logic           h_req_ready,
  input logic           h_req_write,
  input logic [HAW-1:0] h_req_addr,
  input logic           h_rsp_valid,
  input logic           h_rsp_ready,
  input logic [HDW-1:0] h_rsp_rdata,
  input logic           h_rsp_err,
  input logic           i_req_valid,
  input logic           i_req_ready,
  input logic           i_req_write,
  input logic [IAW-1:0] i_req_addr,
  input logic [IDW-1:0] i_req_wdata,
  input logic           i_rsp_err,
  input logic           irq_o,
  input logic           busy,
  input logic           eng_done,
  input logic           err_flag
);

  logic host_take, to_gated, to_clr, err_hit;
  assign host_take = h_req_valid && h_req_ready;
  assign to_gated  = (h_req_addr == HAW'(OFF_HI)) || (h_req_addr == HAW'(OFF_LO)) ||
                     (h_req_addr == HAW'(OFF_CMD));
  assign to_clr    = (h_req_addr == HAW'(OFF_CLR));
  assign err_hit   = eng_done && i_rsp_err;

  // R3
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_take |=> h_rsp_valid);

  // R3
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rsp_valid && !h_rsp_ready) |=>
      (h_rsp_valid && $stable(h_rsp_rdata) && $stable(h_rsp_err)));

  // R6
  ireq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (i_req_valid && !i_req_ready) |=>
      (i_req_valid && $stable(i_req_addr) && $stable(i_req_wdata) && $stable(i_req_write)));

  // R7
  gated_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(host_take && to_gated));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_hit |=> err_flag);

  // R9
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_take && h_req_write && to_clr && !err_hit) |=> !err_flag);

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> err_flag);

endmodule

bind wide_reg_bridge wide_reg_bridge_chk #(.HAW(HAW), .HDW(HDW), .IAW(IAW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .h_req_valid (h_req_valid),
  .h_req_ready (h_req_ready),
  .h_req_write (h_req_write),
  .h_req_addr  (h_req_addr),
  .h_rsp_valid (h_rsp_valid),
  .h_rsp_ready (h_rsp_ready),
  .h_rsp_rdata (h_rsp_rdata),
  .h_rsp_err   (h_rsp_err),
  .i_req_valid (i_req_valid),
  .i_req_ready (i_req_ready),
  .i_req_write (i_req_write),
  .i_req_addr  (i_req_addr),
  .i_req_wdata (i_req_wdata),
  .i_rsp_err   (i_rsp_err),
  .irq_o       (irq_o),
  .busy        (busy),
  .eng_done    (eng_done),
  .err_flag    (err_flag)
);

// File: tb/wide_reg_bridge_test.sv
module wide_reg_bridge_test;

  localparam int HAW = 8;
  localparam int HDW = 32;
  localparam int IAW = 20;
  localparam int IDW = 64;
  localparam logic [IAW-1:0] IBASE = 20'h00100;
  localparam logic [IAW-1:0] BASE  = 20'h70000 + IBASE;

  localparam logic [7:0] A_HI = 8'h00, A_LO = 8'h04, A_CMD = 8'h08,
                         A_CLR = 8'h18, A_STAT = 8'h1C, A_IRQ = 8'h20;

  logic clk = 0, rst_n = 0;
  logic           h_req_valid = 0, h_req_write = 0, h_rsp_ready = 1;
  logic [HAW-1:0] h_req_addr = '0;
  logic [HDW-1:0] h_req_wdata = '0;
  logic           h_req_ready, h_rsp_valid, h_rsp_err;
  logic [HDW-1:0] h_rsp_rdata;
  logic           i_req_valid, i_req_write, irq_o;
  logic [IAW-1:0] i_req_addr;
  logic [IDW-1:0] i_req_wdata;
  logic           i_req_ready = 1, i_rsp_valid = 0, i_rsp_err = 0;
  logic [IDW-1:0] i_rsp_rdata = '0;

  always #10 clk = ~clk;

  wide_reg_bridge uut (
    .clk(clk), .rst_n(rst_n), .inst_base(IBASE),
    .h_req_valid(h_req_valid), .h_req_ready(h_req_ready), .h_req_write(h_req_write),
    .h_req_addr(h_req_addr), .h_req_wdata(h_req_wdata),
    .h_rsp_valid(h_rsp_valid), .h_rsp_ready(h_rsp_ready),
    .h_rsp_rdata(h_rsp_rdata), .h_rsp_err(h_rsp_err),
    .i_req_valid(i_req_valid), .i_req_ready(i_req_ready), .i_req_write(i_req_write),
    .i_req_addr(i_req_addr), .i_req_wdata(i_req_wdata),
    .i_rsp_valid(i_rsp_valid), .i_rsp_rdata(i_rsp_rdata), .i_rsp_err(i_rsp_err),
    .irq_o(irq_o)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // auto responder: 16 mapped 64-bit registers at BASE
  logic [63:0] mem [16];
  bit          resp_auto = 1;
  logic [IAW-1:0] last_addr;
  logic [63:0]    last_wdata;
  logic           last_write;

  initial begin
    for (int k = 0; k < 16; k++) mem[k] = 64'h0;
    forever begin
      @(negedge clk);
      if (resp_auto && i_req_valid && i_req_ready) begin
        last_addr  = i_req_addr;
        last_wdata = i_req_wdata;
        last_write = i_req_write;
        @(negedge clk);
        if ((last_addr - BASE) < 16) begin
          if (last_write) mem[last_addr - BASE] = last_wdata;
          else i_rsp_rdata = mem[last_addr - BASE];
          i_rsp_err = 0;
        end else begin
          i_rsp_err   = 1;
          i_rsp_rdata = 64'hDEAD_DEAD_DEAD_DEAD;
        end
        i_rsp_valid = 1;
        @(negedge clk);
        i_rsp_valid = 0;
        i_rsp_err   = 0;
      end
    end
  end

  // starts and ends at a falling edge
  task automatic host_xfer(input logic wr, input logic [7:0] a, input logic [31:0] wd,
                           output logic [31:0] rd, output logic er);
    h_req_valid = 1; h_req_write = wr; h_req_addr = a; h_req_wdata = wd;
    while (!h_req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    h_req_valid = 0;
    while (!h_rsp_valid) @(negedge clk);
    rd = h_rsp_rdata; er = h_rsp_err;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd_word(input logic [7:0] a, output logic [31:0] rd);
    logic e;
    host_xfer(0, a, 32'h0, rd, e);
  endtask

  task automatic wr_word(input logic [7:0] a, input logic [31:0] wd);
    logic [31:0] d; logic e;
    host_xfer(1, a, wd, d, e);
  endtask

  task automatic wait_idle;
    logic [31:0] s;
    for (int k = 0; k < 40; k++) begin
      rd_word(A_STAT, s);
      if (!s[0]) break;
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 rsp_valid", h_rsp_valid, 0);
    chk("R1 i_req_valid", i_req_valid, 0);
    chk("R1 irq", irq_o, 0);
    rd_word(A_STAT, d); chk("R1 status", d, 0);
    rd_word(A_HI, d);   chk("R1 hi", d, 0);
    rd_word(A_CMD, d);  chk("R1 cmd", d, 0);
    rd_word(A_IRQ, d);  chk("R1 irqen", d, 0);
  endtask

  task automatic t_window;
    logic [31:0] d; logic e;
    wr_word(A_HI, 32'hA5A5_0001);
    wr_word(A_LO, 32'h5A5A_0002);
    rd_word(A_HI, d); chk("R2 hi readback", d, 32'hA5A5_0001);
    rd_word(A_LO, d); chk("R2 lo readback", d, 32'h5A5A_0002);
    host_xfer(0, 8'h10, 0, d, e);
    chk("R2 unmapped err", e, 1); chk("R2 unmapped data", d, 0);
    host_xfer(1, 8'h0C, 32'hFFFF_FFFF, d, e);
    chk("R2 unmapped write err", e, 1);
    rd_word(A_HI, d); chk("R2 unmapped write no effect", d, 32'hA5A5_0001);
    host_xfer(0, A_CLR, 0, d, e);
    chk("R2 reset word reads 0", {31'b0, e, d}, 0);
  endtask

  task automatic t_write_cmd;
    logic [31:0] d;
    wr_word(A_CMD, 32'h8000_0003);
    wait_idle();
    chk("R4 dir", last_write, 1);
    chk("R4 data", last_wdata, 64'hA5A5_0001_5A5A_0002);
    chk("R6 addr", last_addr, BASE + 3);
    rd_word(A_CMD, d); chk("R11 cmd readback", d, 32'h8000_0003);
    rd_word(A_STAT, d); chk("R4 status clean", d, 0);
  endtask

  task automatic t_read_cmd;
    logic [31:0] d;
    mem[5] = 64'h0123_4567_89AB_CDEF;
    wr_word(A_CMD, 32'h0000_0005);
    wait_idle();
    chk("R5 dir", last_write, 0);
    chk("R6 addr", last_addr, BASE + 5);
    rd_word(A_HI, d); chk("R5 hi", d, 32'h0123_4567);
    rd_word(A_LO, d); chk("R5 lo", d, 32'h89AB_CDEF);
    wr_word(A_CMD, 32'h0000_0003);
    wait_idle();
    rd_word(A_HI, d); chk("R4 stored hi", d, 32'hA5A5_0001);
    rd_word(A_LO, d); chk("R4 stored lo", d, 32'h5A5A_0002);
  endtask

  task automatic t_err_irq;
    logic [31:0] d;
    wr_word(A_HI, 32'h1111_1111);
    wr_word(A_LO, 32'h2222_2222);
    wr_word(A_CMD, 32'h0000_0040);
    wait_idle();
    rd_word(A_STAT, d); chk("R8 err set", d, 32'h8000_0000);
    rd_word(A_HI, d); chk("R8 hi kept", d, 32'h1111_1111);
    rd_word(A_LO, d); chk("R8 lo kept", d, 32'h2222_2222);
    chk("R10 irq masked", irq_o, 0);
    wr_word(A_IRQ, 32'h1);
    chk("R10 irq on", irq_o, 1);
    rd_word(A_IRQ, d); chk("R10 enable readback", d, 1);
    rd_word(A_STAT, d); chk("R8 err sticky", d, 32'h8000_0000);
    wr_word(A_CLR, 32'h0);
    rd_word(A_STAT, d); chk("R9 err cleared", d, 0);
    chk("R10 irq off", irq_o, 0);
    wr_word(A_IRQ, 32'h0);
  endtask

  task automatic t_busy;
    logic [31:0] d;
    resp_auto = 0; i_req_ready = 0;
    wr_word(A_CMD, 32'h0000_0002);
    for (int k = 0; k < 3; k++) begin
      chk("R6 req held", {i_req_valid, i_req_write}, 2'b10);
      chk("R6 addr held", i_req_addr, BASE + 2);
      @(negedge clk);
    end
    i_req_ready = 1;
    @(negedge clk);
    h_req_valid = 1; h_req_write = 0; h_req_addr = A_HI;
    for (int k = 0; k < 4; k++) begin
      chk("R7 data word stalled", h_req_ready, 0);
      @(negedge clk);
    end
    h_req_addr = A_CMD; #1;
    chk("R7 cmd stalled", h_req_ready, 0);
    h_req_valid = 0;
    @(negedge clk);
    rd_word(A_STAT, d); chk("R7 busy bit", d, 32'h1);
    i_rsp_valid = 1; i_rsp_err = 0; i_rsp_rdata = 64'h1111_2222_3333_4444;
    @(posedge clk); @(negedge clk);
    i_rsp_valid = 0;
    rd_word(A_STAT, d); chk("R7 busy clear", d, 0);
    rd_word(A_HI, d); chk("R5 hi manual", d, 32'h1111_2222);
    rd_word(A_LO, d); chk("R5 lo manual", d, 32'h3333_4444);
  endtask

  task automatic collide(input logic rsp_err, input logic [63:0] rdat);
    wr_word(A_CMD, 32'h0000_0007);
    while (i_req_valid) @(negedge clk);
    h_req_valid = 1; h_req_write = 1; h_req_addr = A_CLR; h_req_wdata = 0;
    i_rsp_valid = 1; i_rsp_err = rsp_err; i_rsp_rdata = rdat;
    #1;
    chk("R9 reset served while busy", h_req_ready, 1);
    @(posedge clk); @(negedge clk);
    h_req_valid = 0; i_rsp_valid = 0; i_rsp_err = 0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_collision;
    logic [31:0] d;
    collide(1, 64'h0);
    rd_word(A_STAT, d); chk("R9 set wins over clear", d, 32'h8000_0000);
    collide(0, 64'hCAFE_0000_0000_BEEF);
    rd_word(A_STAT, d); chk("R9 clear with clean response", d, 0);
    rd_word(A_HI, d); chk("R5 hi after collision", d, 32'hCAFE_0000);
    resp_auto = 1;
  endtask

  task automatic t_backpressure;
    logic [31:0] d0;
    h_rsp_ready = 0;
    h_req_valid = 1; h_req_write = 0; h_req_addr = A_LO;
    @(posedge clk); @(negedge clk);
    h_req_addr = A_STAT;
    d0 = h_rsp_rdata;
    chk("R3 rsp valid", h_rsp_valid, 1);
    chk("R3 rsp data", d0, 32'h0000_BEEF);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R3 rsp held", {h_rsp_valid, h_rsp_rdata}, {1'b1, 32'h0000_BEEF});
      chk("R3 no new accept", h_req_ready, 0);
    end
    h_req_valid = 0;
    h_rsp_ready = 1;
    @(posedge clk); @(negedge clk);
    chk("R3 rsp consumed", h_rsp_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_window();
    t_write_cmd();
    t_read_cmd();
    t_err_irq();
    t_busy();
    t_collision();
    t_backpressure();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule